// File: doc/BRIEF.md
# Clock-Buffer Output-Enable Serial Slave

This block is the configuration front end of a multi-output differential clock buffer. It listens on a two-wire serial bus (SCL and SDA), which it oversamples with a fast system clock. It holds a bank of seven 8-bit registers whose bits switch the buffer's ten output pairs on or off. There is no sub-address. Every transfer starts at register 0, moves upward one register per byte, and may stop after any complete byte.

A host writes by sending the write address, then a command byte and a count byte. The slave acknowledges both and throws them away. Data bytes follow and fill registers 0 to 6 in order. A host reads by sending the read address. The slave returns a count byte of 7, followed by registers 0 to 6. The slave pulls SDA low only through an open-drain enable. The system clock must run many times faster than SCL.

Top module: `clkctl_smbus_slave`

## Requirements
- R1: After reset all seven registers hold 0xFF, every bit of `clkEn` is 1 and `sdaOe` is 0.
- R2: Address byte 0xD4 (write) and 0xD5 (read) are acknowledged. Any other address byte gets no acknowledge, and the bytes that follow it until the next start get no acknowledge and change no register.
- R3: In a write, the first two bytes after the address are acknowledged, and their values never reach a register.
- R4: Write data bytes land in registers 0, 1, 2 … 6 in arrival order, and each byte is acknowledged.
- R5: A stop after any complete byte ends the write. Registers not reached keep their earlier values.
- R6: A read returns the count byte 0x07 and then registers 0 to 6 in order, each sent MSB first. SDA changes only while SCL is low.
- R7: If the host answers a read byte with a NACK (SDA high during the acknowledge clock), the slave releases SDA. It drives nothing more until the next start; a further byte clocked out reads as 0xFF.
- R8: A write byte that would go past register 6 gets a NACK and is dropped.
- R9: `clkEn[0..4]` follow bits 7, 6, 5, 4, 3 of register 6. `clkEn[9]` follows bit 2 of register 6. `clkEn[5..8]` follow bits 1, 2, 3, 4 of register 5. A bit value of 1 means enabled.
- R10: Bits 7:5 of register 5 stay 1 whatever is written to them.
- R11: A start in the middle of a transfer (a repeated start) ends that transfer and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin (wired bus level) |
| sdaOe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| clkEn | output | 10 | Per-pair output enable, bit n for clock pair n |

## Verification
Faults in the register index or in the write strobe show up in two places. The `clkEn` pattern is wrong as soon as the stop ends the write, and the next read returns the wrong bytes. A bit counter or state that is out of step shows up within one byte. The acknowledge bit then arrives on the wrong clock, or a data bit is shifted, and the host sees it at its next acknowledge sample. A read index that slips shows up in the first read byte after the slip. Because of this, the bench follows every write with a read-back and compares `clkEn` after every transfer.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned NUM_REGS = 7;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS + 1);
  localparam int unsigned BYTE_W   = $clog2(NUM_REGS + 3);
  localparam int unsigned NUM_OUT  = 10;
  localparam int unsigned LOCK_REG = 5;
  localparam logic [7:0]  LOCK_MASK = 8'hE0;

  // strobes from control to datapath
  typedef struct packed {
    logic             shiftIn;
    logic             regWr;
    logic [IDX_W-1:0] regIdx;
    logic             txLoad;
    logic [IDX_W-1:0] txSel;   // 0 selects the count byte
    logic             txShift;
  } dpCtl_t;

  // bus events and data from datapath to control
  typedef struct packed {
    logic       sclRise;
    logic       sclFall;
    logic       sclHigh;
    logic       sdaBit;
    logic       startDet;
    logic       stopDet;
    logic       txBit;
    logic [7:0] rxByte;
  } busEvt_t;

  function automatic int unsigned enReg(input int unsigned o);
    return (o >= 5 && o <= 8) ? 5 : 6;
  endfunction

  function automatic int unsigned enBit(input int unsigned o);
    if (o <= 4) return 7 - o;
    else if (o == 9) return 2;
    else return o - 4;
  endfunction
endpackage

// File: rtl/clkctl_dp.sv
module clkctl_dp
  import clkctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  dpCtl_t             ctl,
  output busEvt_t            ev,
  output logic [NUM_OUT-1:0] clkEn
);
  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic [7:0] rxShift, txShift, txSrc;
  logic [NUM_REGS-1:0][7:0] regFile;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_comb begin
    ev          = '0;
    ev.sclRise  = sclS & ~sclPrev;
    ev.sclFall  = ~sclS & sclPrev;
    ev.sclHigh  = sclS;
    ev.sdaBit   = sdaS;
    ev.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.txBit    = txShift[7];
    ev.rxByte   = rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= 8'h00;
    else if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaS};
  end

  // register file, locked bits keep their value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '1;
    end else if (ctl.regWr) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (ctl.regIdx == IDX_W'(r)) begin
          if (r == LOCK_REG)
            regFile[r] <= (rxShift & ~LOCK_MASK) | (regFile[r] & LOCK_MASK);
          else
            regFile[r] <= rxShift;
        end
      end
    end
  end

  always_comb begin
    txSrc = 8'(NUM_REGS);
    for (int r = 0; r < NUM_REGS; r++)
      if (ctl.txSel == IDX_W'(r + 1)) txSrc = regFile[r];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= 8'hFF;
    else if (ctl.txLoad) txShift <= txSrc;
    else if (ctl.txShift) txShift <= {txShift[6:0], 1'b1};
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_en
    assign clkEn[o] = regFile[enReg(o)][enBit(o)];
  end

  p_lock_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.regWr && ctl.regIdx == IDX_W'(LOCK_REG))
      |=> ((regFile[LOCK_REG] & LOCK_MASK) == ($past(regFile[LOCK_REG]) & LOCK_MASK)));
endmodule

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t ev,
  output dpCtl_t  ctl,
  output logic    sdaOe
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_RX, S_TX, S_MACK, S_WAIT} state_t;

  state_t            state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] byteNum;
  logic [IDX_W-1:0]  txIdx;
  logic              readMode, ackOe, hostAck;
  logic              busEvt, addrOk, byteDone, roomLeft;

  assign busEvt   = ev.startDet | ev.stopDet;
  assign addrOk   = (ev.rxByte[7:1] == DEV_ADDR);
  assign byteDone = ev.sclFall && bitCnt == 4'd8;
  assign roomLeft = byteNum <= BYTE_W'(NUM_REGS + 1);

  always_comb begin
    ctl        = '0;
    ctl.regIdx = IDX_W'(byteNum - BYTE_W'(2));
    ctl.txSel  = txIdx;
    if (!busEvt) begin
      if ((state == S_ADDR || state == S_RX) && ev.sclRise && bitCnt < 4'd8)
        ctl.shiftIn = 1'b1;
      if (state == S_RX && byteDone && byteNum >= BYTE_W'(2) && roomLeft)
        ctl.regWr = 1'b1;
      if (state == S_ACK && ev.sclFall && readMode)
        ctl.txLoad = 1'b1;
      if (state == S_MACK && ev.sclFall && hostAck && txIdx < IDX_W'(NUM_REGS)) begin
        ctl.txLoad = 1'b1;
        ctl.txSel  = txIdx + IDX_W'(1);
      end
      if (state == S_TX && ev.sclFall && bitCnt < 4'd7)
        ctl.txShift = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      byteNum  <= '0;
      txIdx    <= '0;
      readMode <= 1'b0;
      ackOe    <= 1'b0;
      hostAck  <= 1'b0;
    end else if (ev.startDet) begin
      state   <= S_ADDR;
      bitCnt  <= '0;
      byteNum <= '0;
      txIdx   <= '0;
      ackOe   <= 1'b0;
    end else if (ev.stopDet) begin
      state <= S_IDLE;
      ackOe <= 1'b0;
    end else begin
      unique case (state)
        S_ADDR, S_RX: begin
          if (ev.sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            if (state == S_ADDR) begin
              if (addrOk) begin
                readMode <= ev.rxByte[0];
                ackOe    <= 1'b1;
                state    <= S_ACK;
              end else begin
                state <= S_WAIT;
              end
            end else if (roomLeft) begin
              byteNum <= byteNum + BYTE_W'(1);
              ackOe   <= 1'b1;
              state   <= S_ACK;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_ACK: if (ev.sclFall) begin
          ackOe  <= 1'b0;
          bitCnt <= '0;
          state  <= readMode ? S_TX : S_RX;
        end
        S_TX: if (ev.sclFall) begin
          if (bitCnt == 4'd7) state <= S_MACK;
          else bitCnt <= bitCnt + 4'd1;
        end
        S_MACK: begin
          if (ev.sclRise) hostAck <= ~ev.sdaBit;
          if (ev.sclFall) begin
            if (hostAck && txIdx < IDX_W'(NUM_REGS)) begin
              txIdx  <= txIdx + IDX_W'(1);
              bitCnt <= '0;
              state  <= S_TX;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = ackOe | (state == S_TX && !ev.txBit);

  p_sda_hold_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ev.sclHigh && $past(ev.sclHigh)) |-> $stable(sdaOe));
  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.regWr |=> sdaOe);
  p_foreign_nack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && byteDone && !busEvt && !addrOk) |=> !sdaOe);
  p_overflow_nack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX && byteDone && !busEvt && !roomLeft) |=> !sdaOe);
  p_nack_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MACK && ev.sclFall && !busEvt && !hostAck) |=> (state == S_WAIT && !sdaOe));
  p_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    ev.startDet |=> (state == S_ADDR && bitCnt == 4'd0));
endmodule

// File: rtl/clkctl_smbus_slave.sv
module clkctl_smbus_slave
  import clkctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  output logic [NUM_OUT-1:0] clkEn
);
  dpCtl_t  ctl;
  busEvt_t ev;

  clkctl_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .ctl   (ctl),
    .ev    (ev),
    .clkEn (clkEn)
  );

  clkctl_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ev    (ev),
    .ctl   (ctl),
    .sdaOe (sdaOe)
  );
endmodule

// File: tb/clkctl_smbus_slave_bench.sv
module clkctl_smbus_slave_bench;
  localparam int QTR = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       hostSda = 1'b1;
  logic       sdaOe;
  logic [9:0] clkEn;
  wire        sdaBus = hostSda & ~sdaOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] model [7];
  logic [7:0] wrBuf [10];

  always #2 clk = ~clk;

  clkctl_smbus_slave u_clkctl_smbus_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .clkEn(clkEn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  function automatic logic [9:0] expEn();
    logic [9:0] e;
    for (int i = 0; i < 5; i++) e[i] = model[6][7-i];
    e[9] = model[6][2];
    for (int i = 5; i < 9; i++) e[i] = model[5][i-4];
    return e;
  endfunction

  function automatic logic [7:0] stored(input int r, input logic [7:0] d);
    return (r == 5) ? (d | 8'hE0) : d;
  endfunction

  task automatic busStart();
    hostSda = 1'b1; q();
    sclLine = 1'b1; q();
    hostSda = 1'b0; q();
    sclLine = 1'b0; q();
  endtask

  task automatic busStop();
    hostSda = 1'b0; q();
    sclLine = 1'b1; q();
    hostSda = 1'b1; q();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hostSda = b[i]; q();
      sclLine = 1'b1; q(); q();
      sclLine = 1'b0; q();
    end
    hostSda = 1'b1; q();
    sclLine = 1'b1; q();
    acked = ~sdaBus;
    q();
    sclLine = 1'b0; q();
  endtask

  task automatic recvByte(output logic [7:0] b, input bit giveAck);
    hostSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      sclLine = 1'b1; q();
      b[i] = sdaBus;
      q();
      sclLine = 1'b0;
    end
    q();
    hostSda = ~giveAck; q();
    sclLine = 1'b1; q(); q();
    sclLine = 1'b0; q();
    hostSda = 1'b1;
  endtask

  // block write: cmd and count bytes then nData bytes from wrBuf
  task automatic hostWrite(input logic [7:0] addr, input int nData);
    bit a;
    busStart();
    sendByte(addr, a);
    chk(a == (addr == 8'hD4), "R2 address ack", a, addr == 8'hD4);
    if (!a) begin
      sendByte(8'h00, a); chk(!a, "R2 ignored after foreign address", a, 0);
      sendByte(8'h00, a); chk(!a, "R2 ignored after foreign address", a, 0);
      busStop();
      return;
    end
    sendByte(8'($urandom), a); chk(a, "R3 command ack", a, 1);
    sendByte(8'($urandom), a); chk(a, "R3 count ack", a, 1);
    for (int i = 0; i < nData; i++) begin
      sendByte(wrBuf[i], a);
      if (i < 7) begin
        chk(a, "R4 data ack", a, 1);
        model[i] = stored(i, wrBuf[i]);
      end else begin
        chk(!a, "R8 overflow nack", a, 0);
        break;
      end
    end
    busStop();
    chk(clkEn == expEn(), "R9 enable map", clkEn, expEn());
  endtask

  task automatic hostRead(input int nBytes);
    bit a;
    logic [7:0] b;
    logic [7:0] e;
    busStart();
    sendByte(8'hD5, a);
    chk(a, "R2 read address ack", a, 1);
    for (int k = 0; k < nBytes; k++) begin
      recvByte(b, k != nBytes - 1);
      e = (k == 0) ? 8'h07 : model[k-1];
      chk(b == e, "R6 read byte", b, e);
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    void'($urandom(32'd9127));
    for (int r = 0; r < 7; r++) model[r] = 8'hFF;
    repeat (5) @(posedge clk);
    #1;
    chk(clkEn == 10'h3FF, "R1 reset enables", clkEn, 10'h3FF);
    chk(sdaOe == 1'b0, "R1 reset sdaOe", sdaOe, 0);
    rstN = 1'b1;
    q();
    hostRead(8);  // R1 registers read 0xFF

    // R3: command/count only, no data
    hostWrite(8'hD4, 0);
    hostRead(8);

    // R4/R9: full write with walking pattern
    for (int i = 0; i < 7; i++) wrBuf[i] = 8'h01 << i;
    wrBuf[6] = 8'hA4;
    wrBuf[5] = 8'h00;  // R10: locked bits stay 1
    hostWrite(8'hD4, 7);
    chk(model[5] == 8'hE0, "R10 locked bits", model[5], 8'hE0);
    hostRead(8);

    // R5: partial write of two bytes
    wrBuf[0] = 8'h5A; wrBuf[1] = 8'hC3;
    hostWrite(8'hD4, 2);
    hostRead(8);

    // R8: nine data bytes, eighth is refused
    for (int i = 0; i < 9; i++) wrBuf[i] = 8'h10 + 8'(i);
    hostWrite(8'hD4, 9);
    hostRead(8);

    // R2: foreign address ignored
    hostWrite(8'hA0, 0);
    hostRead(8);

    // R7: host NACK after three bytes, slave silent afterwards
    busStart();
    sendByte(8'hD5, a);
    recvByte(b, 1); chk(b == 8'h07, "R6 count byte", b, 8'h07);
    recvByte(b, 1); chk(b == model[0], "R6 reg0", b, model[0]);
    recvByte(b, 0); chk(b == model[1], "R6 reg1", b, model[1]);
    recvByte(b, 0); chk(b == 8'hFF, "R7 released after nack", b, 8'hFF);
    busStop();

    // R11: repeated start from write into read
    busStart();
    sendByte(8'hD4, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    sendByte(8'h3C, a); chk(a, "R11 write before restart", a, 1);
    model[0] = 8'h3C;
    busStart();
    sendByte(8'hD5, a); chk(a, "R11 read after restart", a, 1);
    recvByte(b, 1); chk(b == 8'h07, "R11 count", b, 8'h07);
    recvByte(b, 0); chk(b == 8'h3C, "R11 reg0", b, 8'h3C);
    busStop();

    // random mix
    for (int t = 0; t < 18; t++) begin
      int kind = int'($urandom_range(0, 5));
      if (kind <= 2) begin
        int n = int'($urandom_range(0, 8));
        for (int i = 0; i < 10; i++) wrBuf[i] = 8'($urandom);
        hostWrite(8'hD4, n);
      end else if (kind <= 4) begin
        hostRead(int'($urandom_range(1, 8)));
      end else begin
        hostWrite({7'($urandom), 1'b0} | 8'h02, 0);
      end
      chk(clkEn == expEn(), "R9 enables after transfer", clkEn, expEn());
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule